// File: doc/BRIEF.md
# Four-Bank Interleave Command Generator

This block produces an endless, fixed-shape stream of DDR2 commands that reads all four banks in turn. It is used to load a memory device for current measurement or stress runs. For each bank, taken in ascending order, it issues a row open, then a burst-of-four read with auto precharge to the same bank, then a run of deselect cycles. After the fourth bank a longer deselect run closes the loop, and the pattern repeats from bank 0.

The lengths of the deselect runs are set by a speed-grade input. Each grade has its own fixed pair of gaps, so that consecutive row opens stay spaced correctly and every bank comes back round once per row-cycle time. A start pulse launches the pattern from bank 0. A stop pulse lets the current loop run to its end, tail gap included, and then parks the bus. A loop counter tells a testbench how many complete loops have gone out. Read data is not captured.

Top module: `bank_interleave_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the outputs are: cs_n, ras_n, cas_n and we_n all 1, bank 0, addr 0, loop_count 0.
- R2: Until a start pulse is sampled, the block keeps the bus deselected (cs_n = 1). In the cycle after start is sampled it issues a row open to bank 0.
- R3: Each bank gets a row open, encoded as cs_n/ras_n/cas_n/we_n = 0/0/1/1, and in the next cycle a read to the same bank, encoded as 0/1/0/1. Banks follow the order 0, 1, 2, 3, then wrap to 0.
- R4: A row open drives addr = ROW_BASE + bank, which is 256 + bank by default. A read drives addr = COL_BASE with bit 10 set to request auto precharge, which is 1032 by default.
- R5: The deselect run after banks 0 to 2 and the run after bank 3 have these lengths. Grade 0: 4 and 11. Grade 1: 2 and 9. Grades 2 and 3: 2 and 6.
- R6: In every deselect cycle cs_n is 1, and ras_n, cas_n, we_n, bank and addr keep the values they had in the cycle before.
- R7: The grade is sampled only when a loop begins. A change during a loop takes effect from the next loop.
- R8: A stop pulse during a loop, up to and including the last tail cycle, lets that loop complete and then leaves the bus deselected. A stop pulse while idle has no effect. loop_count increases by one at the end of each completed loop and is not cleared by stop or start.
- R9: A start pulse while the pattern is running has no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin the pattern at bank 0 |
| stop | input | 1 | Pulse to end the pattern after the current loop |
| grade | input | 2 | Speed grade selecting the gap lengths |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | 2 | Bank address |
| addr | output | ADDR_W | Row or column address |
| loop_count | output | LOOP_W | Number of completed loops |

## Verification
On every cycle the assertions check the following. Only the two legal command codes appear. A read follows each row open to the same bank, with the auto-precharge bit set. A read is always followed by a deselect, and a row open is always preceded by one. Every deselect holds the other pins, and the loop counter moves by at most one per cycle. The exact gap lengths for each grade, the bank order, when a grade change takes effect, stopping at the loop boundary, and the ignored start and stop pulses can only be seen from the bench's cycle-exact walk of whole loops.

// File: rtl/bank_interleave_pkg.sv
package bank_interleave_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int AP_BIT    = 10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACT  = 2'd1,
        PH_RDA  = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        GR_FAST = 2'd0,
        GR_MID  = 2'd1,
        GR_SLOW = 2'd2,
        GR_SPARE = 2'd3
    } grade_e;

    typedef struct packed {
        phase_e            phase;
        logic [BANK_W-1:0] bank;
    } step_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic pins_t pins_for(phase_e p);
        pins_t r;
        case (p)
            PH_ACT:  r = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            PH_RDA:  r = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            default: r = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return r;
    endfunction

    function automatic logic is_last_bank(logic [BANK_W-1:0] b);
        return b == BANK_W'(NUM_BANKS - 1);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bank_interleave_gaps.sv
module bank_interleave_gaps
    import bank_interleave_pkg::*;
#(
    parameter int GAP_W = 4,
    parameter int G0_IN = 4,
    parameter int G0_TL = 11,
    parameter int G1_IN = 2,
    parameter int G1_TL = 9,
    parameter int G2_IN = 2,
    parameter int G2_TL = 6
) (
    input  grade_e             grade,
    output logic [GAP_W-1:0]   inner_len,
    output logic [GAP_W-1:0]   tail_len
);

    always_comb begin
        case (grade)
            GR_FAST: begin
                inner_len = GAP_W'(G0_IN);
                tail_len  = GAP_W'(G0_TL);
            end
            GR_MID: begin
                inner_len = GAP_W'(G1_IN);
                tail_len  = GAP_W'(G1_TL);
            end
            default: begin
                inner_len = GAP_W'(G2_IN);
                tail_len  = GAP_W'(G2_TL);
            end
        endcase
    end

endmodule

// File: rtl/bank_interleave_seq.sv
module bank_interleave_seq
    import bank_interleave_pkg::*;
#(
    parameter int GAP_W  = 4,
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [1:0]        grade_in,
    input  logic [GAP_W-1:0]  inner_len,
    input  logic [GAP_W-1:0]  tail_len,
    output grade_e            grade_cur,
    output step_t             nxt,
    output logic [LOOP_W-1:0] loop_count
);

    phase_e            phase_q, phase_d;
    logic [BANK_W-1:0] bank_q,  bank_d;
    logic [GAP_W-1:0]  gap_q,   gap_d;
    grade_e            grade_q, grade_d;
    logic              stop_q,  stop_d;
    logic [LOOP_W-1:0] loop_q,  loop_d;

    always_comb begin
        phase_d = phase_q;
        bank_d  = bank_q;
        gap_d   = gap_q;
        grade_d = grade_q;
        stop_d  = stop_q | (stop && (phase_q != PH_IDLE));
        loop_d  = loop_q;
        case (phase_q)
            PH_IDLE: begin
                stop_d = 1'b0;
                if (start) begin
                    phase_d = PH_ACT;
                    bank_d  = '0;
                    grade_d = grade_e'(grade_in);
                end
            end
            PH_ACT: begin
                phase_d = PH_RDA;
            end
            PH_RDA: begin
                phase_d = PH_GAP;
                gap_d   = (is_last_bank(bank_q) ? tail_len : inner_len) - GAP_W'(1);
            end
            default: begin
                if (gap_q == '0) begin
                    if (is_last_bank(bank_q)) begin
                        loop_d = loop_q + LOOP_W'(1);
                        if (stop_q || stop) begin
                            phase_d = PH_IDLE;
                            stop_d  = 1'b0;
                        end else begin
                            phase_d = PH_ACT;
                            bank_d  = '0;
                            grade_d = grade_e'(grade_in);
                        end
                    end else begin
                        phase_d = PH_ACT;
                        bank_d  = bank_q + BANK_W'(1);
                    end
                end else begin
                    gap_d = gap_q - GAP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            bank_q  <= '0;
            gap_q   <= '0;
            grade_q <= GR_FAST;
            stop_q  <= 1'b0;
            loop_q  <= '0;
        end else begin
            phase_q <= phase_d;
            bank_q  <= bank_d;
            gap_q   <= gap_d;
            grade_q <= grade_d;
            stop_q  <= stop_d;
            loop_q  <= loop_d;
        end
    end

    assign nxt        = '{phase: phase_d, bank: bank_d};
    assign grade_cur  = grade_q;
    assign loop_count = loop_q;

endmodule

// File: rtl/bank_interleave_drv.sv
module bank_interleave_drv
    import bank_interleave_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int ROW_BASE = 256,
    parameter int COL_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             nxt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] COL_AP = ADDR_W'(COL_BASE) | (ADDR_W'(1) << AP_BIT);

    logic [ADDR_W-1:0] row_tab [NUM_BANKS];
    pins_t             pins_n;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
        assign row_tab[b] = ADDR_W'(ROW_BASE + b);
    end

    assign pins_n = pins_for(nxt.phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n  <= 1'b1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            bank  <= '0;
            addr  <= '0;
        end else begin
            cs_n <= pins_n.cs_n;
            if (nxt.phase == PH_ACT || nxt.phase == PH_RDA) begin
                ras_n <= pins_n.ras_n;
                cas_n <= pins_n.cas_n;
                we_n  <= pins_n.we_n;
                bank  <= nxt.bank;
                addr  <= (nxt.phase == PH_ACT) ? row_tab[nxt.bank] : COL_AP;
            end
        end
    end

endmodule

// File: rtl/bank_interleave_gen.sv
module bank_interleave_gen
    import bank_interleave_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int LOOP_W   = 16,
    parameter int ROW_BASE = 256,
    parameter int COL_BASE = 8,
    parameter int G0_IN    = 4,
    parameter int G0_TL    = 11,
    parameter int G1_IN    = 2,
    parameter int G1_TL    = 9,
    parameter int G2_IN    = 2,
    parameter int G2_TL    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [1:0]        grade,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        bank,
    output logic [ADDR_W-1:0] addr,
    output logic [LOOP_W-1:0] loop_count
);

    localparam int GAP_MAX = imax(imax(imax(G0_IN, G0_TL), imax(G1_IN, G1_TL)),
                                  imax(G2_IN, G2_TL));
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    grade_e           grade_cur;
    logic [GAP_W-1:0] inner_len;
    logic [GAP_W-1:0] tail_len;
    step_t            nxt;

    bank_interleave_gaps #(
        .GAP_W(GAP_W),
        .G0_IN(G0_IN), .G0_TL(G0_TL),
        .G1_IN(G1_IN), .G1_TL(G1_TL),
        .G2_IN(G2_IN), .G2_TL(G2_TL)
    ) u_gaps (
        .grade     (grade_cur),
        .inner_len (inner_len),
        .tail_len  (tail_len)
    );

    bank_interleave_seq #(
        .GAP_W (GAP_W),
        .LOOP_W(LOOP_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .stop       (stop),
        .grade_in   (grade),
        .inner_len  (inner_len),
        .tail_len   (tail_len),
        .grade_cur  (grade_cur),
        .nxt        (nxt),
        .loop_count (loop_count)
    );

    bank_interleave_drv #(
        .ADDR_W  (ADDR_W),
        .ROW_BASE(ROW_BASE),
        .COL_BASE(COL_BASE)
    ) u_drv (
        .clk   (clk),
        .rst   (rst),
        .nxt   (nxt),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .bank  (bank),
        .addr  (addr)
    );

endmodule

// File: rtl/bank_interleave_chk.sv
module bank_interleave_chk #(
    parameter int ADDR_W = 14,
    parameter int LOOP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [1:0]        bank,
    input logic [ADDR_W-1:0] addr,
    input logic [LOOP_W-1:0] loop_count
);

    logic armed;
    logic is_act;
    logic is_rd;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign is_act = !cs_n && !ras_n;
    assign is_rd  = !cs_n && ras_n && !cas_n;

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (we_n && (ras_n != cas_n)));  // R3

    AST_RD_FOLLOWS_ACT: assert property (@(posedge clk) disable iff (rst || !armed)
        is_act |=> (is_rd && bank == $past(bank)));  // R3

    AST_RD_AUTOPRE: assert property (@(posedge clk) disable iff (rst)
        is_rd |-> addr[10]);  // R4

    AST_GAP_AFTER_RD: assert property (@(posedge clk) disable iff (rst || !armed)
        is_rd |=> cs_n);  // R5

    AST_ACT_AFTER_GAP: assert property (@(posedge clk) disable iff (rst || !armed)
        is_act |-> $past(cs_n));  // R5

    AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        cs_n |-> ($stable(ras_n) && $stable(cas_n) && $stable(we_n)
                  && $stable(bank) && $stable(addr)));  // R6

    AST_LOOP_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
        (loop_count == $past(loop_count)) || (loop_count == $past(loop_count) + LOOP_W'(1)));  // R8

endmodule

bind bank_interleave_gen bank_interleave_chk #(
    .ADDR_W(ADDR_W),
    .LOOP_W(LOOP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .bank       (bank),
    .addr       (addr),
    .loop_count (loop_count)
);

// File: tb/bank_interleave_gen_test.sv
module bank_interleave_gen_test;

    localparam int ADDR_W = 14;
    localparam int LOOP_W = 16;
    localparam int ROW0   = 256;
    localparam int COL_AP = 8 + 1024;

    typedef struct packed {
        logic [1:0] g;
        int         in_g;
        int         tl_g;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{g: 2'd0, in_g: 4, tl_g: 11},
        '{g: 2'd1, in_g: 2, tl_g: 9},
        '{g: 2'd2, in_g: 2, tl_g: 6},
        '{g: 2'd3, in_g: 2, tl_g: 6}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic [1:0]        grade = 2'd0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [1:0]        bank;
    logic [ADDR_W-1:0] addr;
    logic [LOOP_W-1:0] loop_count;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cycles   = 0;
    bit  done     = 1'b0;

    logic              e_ras, e_cas, e_we;
    logic [1:0]        e_bank;
    logic [ADDR_W-1:0] e_addr;

    always #5 clk = ~clk;

    bank_interleave_gen uut (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .grade(grade),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank(bank), .addr(addr), .loop_count(loop_count)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_bus(input logic ecs, input string req);
        logic [19:0] a, e;
        a = {cs_n, ras_n, cas_n, we_n, bank, addr};
        e = {ecs, e_ras, e_cas, e_we, e_bank, e_addr};
        check(a === e, req, "bus {cs,ras,cas,we,bank,addr}", longint'(a), longint'(e));
    endtask

    task automatic exp_act(input int b);
        e_ras = 1'b0; e_cas = 1'b1; e_we = 1'b1;
        e_bank = 2'(b); e_addr = ADDR_W'(ROW0 + b);
        chk_bus(1'b0, "R3");
    endtask

    task automatic exp_rd(input int b);
        e_ras = 1'b1; e_cas = 1'b0; e_we = 1'b1;
        e_bank = 2'(b); e_addr = ADDR_W'(COL_AP);
        chk_bus(1'b0, "R4");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; stop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e_ras = 1'b1; e_cas = 1'b1; e_we = 1'b1; e_bank = 2'd0; e_addr = '0;
    endtask

    task automatic walk_loop(input int inner, input int tail, input int start_at,
                             input int stop_at, input int grade_at,
                             input logic [1:0] new_grade, input string req);
        int idx = 0;
        for (int b = 0; b < 4; b++) begin
            int gap = (b == 3) ? tail : inner;
            for (int k = 0; k < gap + 2; k++) begin
                if (k == 0)      exp_act(b);
                else if (k == 1) exp_rd(b);
                else             chk_bus(1'b1, req);
                start = (idx == start_at);
                stop  = (idx == stop_at);
                if (idx == grade_at) grade = new_grade;
                idx++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        stop  = 1'b0;
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk_bus(1'b1, req);
            @(negedge clk);
        end
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check(cs_n === 1'b1 && ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1,
              "R1", "control pins", {cs_n, ras_n, cas_n, we_n}, 4'hF);
        check(bank === 2'd0 && addr === '0, "R1", "bank/addr", {bank, addr}, 0);
        check(loop_count === '0, "R1", "loop_count", loop_count, 0);
        // R2: no start, bus stays deselected
        expect_idle(5, "R2");

        // Table of grades: two loops each, ignored start in loop 1, stop in loop 2
        for (int v = 0; v < 4; v++) begin
            do_reset();
            grade = VECS[v].g;
            start = 1'b1;
            @(negedge clk);
            walk_loop(VECS[v].in_g, VECS[v].tl_g, 3, -1, -1, 2'd0, "R5 R6 R9");
            check(loop_count === 16'd1, "R8", "loop_count after loop 1", loop_count, 1);
            walk_loop(VECS[v].in_g, VECS[v].tl_g, -1, 10, -1, 2'd0, "R5 R6 R8");
            check(loop_count === 16'd2, "R8", "loop_count after stop", loop_count, 2);
            expect_idle(3, "R8");
            check(loop_count === 16'd2, "R8", "loop_count while idle", loop_count, 2);
        end

        // R7: grade change mid-loop applies from the next loop; stop on last tail cycle
        do_reset();
        grade = 2'd0;
        start = 1'b1;
        @(negedge clk);
        walk_loop(4, 11, -1, -1, 5, 2'd2, "R7");
        walk_loop(2, 6, -1, 19, -1, 2'd2, "R7 R8");
        check(loop_count === 16'd2, "R8", "loop_count, late stop", loop_count, 2);
        expect_idle(4, "R8");

        // R8: stop while idle is ignored; restart keeps the loop count
        do_reset();
        grade = 2'd1;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        expect_idle(2, "R2 R8");
        start = 1'b1;
        @(negedge clk);
        walk_loop(2, 9, -1, -1, -1, 2'd1, "R8");
        check(loop_count === 16'd1, "R8", "no stale stop", loop_count, 1);
        walk_loop(2, 9, -1, 0, -1, 2'd1, "R8");
        expect_idle(2, "R8");
        start = 1'b1;
        @(negedge clk);
        walk_loop(2, 9, -1, 4, -1, 2'd1, "R2 R8");
        check(loop_count === 16'd3, "R8", "count kept over restart", loop_count, 3);

        // R1: reset in the middle of a loop
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(cs_n === 1'b1 && ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1,
              "R1", "pins after mid-run reset", {cs_n, ras_n, cas_n, we_n}, 4'hF);
        check(bank === 2'd0 && addr === '0 && loop_count === '0, "R1",
              "bank/addr/count after mid-run reset", {bank, addr, loop_count}, 0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
    end

endmodule